// File: doc/BRIEF.md
# JTAG User-Register Memory Bridge

This block lets a JTAG host read and write memories inside a chip. It sits behind the chip's embedded JTAG access primitive, which provides a test clock, a TAP reset, a shift enable, an update strobe and a serial input, and it drives the serial output back. The host shifts one 39-bit frame through a user data register. The frame holds an operation code, a block index, an address and write data. When the update strobe arrives, the bridge carries the request into the system-clock domain. There it runs one handshaked read or write on a generic memory bus, or it answers a geometry query.

The memory bus has a strobe, separate read and write enables, one chip select per memory block, an address, write data and read data. Each transfer ends when the memory raises acknowledge. Each block has its own address and data width. Narrow fields are right-aligned and the unused upper bits are forced to zero. The next shift returns the read data, or the answer to the geometry query. The active levels of both resets and of the shift enable are parameters.

Top module: `jtag_mem_bridge`

## Requirements
- R1: While shift enable is active, each rising TCK edge moves the 39-bit register one place toward TDO. TDI enters at bit 38 and TDO presents bit 0. The frame layout, from bit 0 upward, is: operation code [1:0] (00 idle, 01 read, 10 write, 11 geometry query), block index [3:2], address [22:4], data [38:23].
- R2: On the first shifting TCK edge after a period without shifting, the register is reloaded from the result word. The bits that appear on TDO during that shift are therefore a frame whose data field [38:23] holds the 16-bit result and whose other bits are zero.
- R3: The TCK edge that samples update high latches the frame. A read or write then raises strobe at the third system-clock rising edge after that TCK edge, and each update yields at most one access.
- R4: Strobe stays high until acknowledge is sampled high. Until then chip select, address, data out, read and write hold steady. Strobe drops at the edge that samples acknowledge.
- R5: Read and write are never both high. A read code raises only read and a write code raises only write, and exactly one of them is high while strobe is high.
- R6: While strobe is high, chip select is one-hot with bit n set for block index n. While strobe is low, chip select is all zero.
- R7: Block widths (address/data) are 18/16, 18/16, 19/8 and 8/8 for blocks 0 to 3. The address out and the write data out keep only the low bits of the selected block's widths, and the bits above are zero.
- R8: When a read is acknowledged, read data masked to the block's data width becomes the result word.
- R9: A geometry query starts no access. It sets the result to the block's address width in bits [15:8] and its data width in bits [7:0].
- R10: An idle code starts no access and leaves the result unchanged.
- R11: An update whose synchronised edge arrives while strobe is high starts nothing and is not queued. This includes an edge that arrives in the cycle in which acknowledge is sampled.
- R12: TAP reset clears the shift register and the latched frame to idle, so a following update starts nothing. System reset drops strobe and clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock from the JTAG primitive |
| tap_rst_i | input | 1 | TAP reset, level set by parameter |
| shift_en_i | input | 1 | Shift enable for the user register, level set by parameter |
| update_i | input | 1 | Update strobe, sampled on TCK |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| sys_clk_i | input | 1 | System clock for the memory bus |
| sys_rst_i | input | 1 | System reset, level set by parameter |
| mem_strobe_o | output | 1 | Transfer in progress |
| mem_rd_o | output | 1 | Read enable |
| mem_wr_o | output | 1 | Write enable |
| mem_ack_i | input | 1 | Transfer acknowledge from the memory |
| mem_cs_o | output | 4 | One-hot block select |
| mem_addr_o | output | 19 | Address, right-aligned to the block width |
| mem_din_i | input | 16 | Read data from the memory |
| mem_dout_o | output | 16 | Write data, right-aligned to the block width |

## Verification
A new synchronised update edge and the acknowledge of the running transfer can land in the same system-clock cycle. The bridge must then drop the new request rather than start a second transfer or corrupt the one that is ending. The bench provokes this with a fixed acknowledge latency: it repeats the update pulse for a stalled transfer and sweeps the delay before the repeat over a range of cycles, so that one setting puts the repeat on the acknowledge cycle and its neighbours fall just before and just after it. A per-cycle model run by the bench from the same stimulus decides in each case whether a transfer must follow, and it compares every bus output on every clock.

// File: rtl/jmb_pkg.sv
`timescale 1ns/1ps
package jmb_pkg;
  localparam int NBLK    = 4;
  localparam int BLK_W   = $clog2(NBLK);
  localparam int ADDR_W  = 19;
  localparam int DATA_W  = 16;
  localparam int CMD_W   = 2;
  localparam int FRAME_W = CMD_W + BLK_W + ADDR_W + DATA_W;
  localparam int WID_W   = DATA_W / 2;

  typedef enum logic [CMD_W-1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_QUERY = 2'b11
  } op_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic [ADDR_W-1:0] addr;
    logic [BLK_W-1:0]  blk;
    op_e               op;
  } frame_t;

  // per-block geometry
  function automatic int addr_bits(input int b);
    case (b)
      0, 1:    return 18;
      2:       return 19;
      default: return 8;
    endcase
  endfunction

  function automatic int data_bits(input int b);
    case (b)
      0, 1:    return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] addr_mask(input logic [BLK_W-1:0] b);
    return ADDR_W'(((ADDR_W+1)'(1) << addr_bits(int'(b))) - (ADDR_W+1)'(1));
  endfunction

  function automatic logic [DATA_W-1:0] data_mask(input logic [BLK_W-1:0] b);
    return DATA_W'(((DATA_W+1)'(1) << data_bits(int'(b))) - (DATA_W+1)'(1));
  endfunction

  function automatic logic [DATA_W-1:0] geometry_word(input logic [BLK_W-1:0] b);
    return {WID_W'(addr_bits(int'(b))), WID_W'(data_bits(int'(b)))};
  endfunction

  function automatic logic [NBLK-1:0] block_select(input logic [BLK_W-1:0] b);
    return NBLK'(1) << b;
  endfunction

  function automatic logic [FRAME_W-1:0] result_frame(input logic [DATA_W-1:0] r);
    frame_t f;
    f      = '0;
    f.data = r;
    return f;
  endfunction
endpackage

// File: rtl/jmb_scan_reg.sv
`timescale 1ns/1ps
module jmb_scan_reg
  import jmb_pkg::*;
#(
  parameter logic SHIFT_ACT   = 1'b1,
  parameter logic TAP_RST_ACT = 1'b1
) (
  input  logic              tck_i,
  input  logic              tap_rst_i,
  input  logic              shift_i,
  input  logic              update_i,
  input  logic              tdi_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              tdo_o,
  output frame_t            frame_o,
  output logic              upd_lvl_o
);
  logic [FRAME_W-1:0] sr_q;
  logic               shifting_q;
  logic [FRAME_W-1:0] cap_w;
  logic               rst_w;
  logic               shift_w;

  assign rst_w   = (tap_rst_i == TAP_RST_ACT);
  assign shift_w = (shift_i == SHIFT_ACT);
  assign cap_w   = result_frame(result_i);

  always_ff @(posedge tck_i) begin
    if (rst_w) begin
      sr_q       <= '0;
      shifting_q <= 1'b0;
      frame_o    <= '0;
      upd_lvl_o  <= 1'b0;
    end else begin
      shifting_q <= shift_w;
      if (shift_w)
        sr_q <= shifting_q ? {tdi_i, sr_q[FRAME_W-1:1]} : {tdi_i, cap_w[FRAME_W-1:1]};
      upd_lvl_o <= update_i;
      if (update_i)
        frame_o <= frame_t'(sr_q);
    end
  end

  // the first shifted bit comes straight from the result word
  assign tdo_o = shifting_q ? sr_q[0] : cap_w[0];
endmodule

// File: rtl/jmb_edge_sync.sv
`timescale 1ns/1ps
module jmb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic level_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) pipe_q <= '0;
    else       pipe_q <= {pipe_q[STAGES-1:0], level_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/jmb_mem_ctrl.sv
`timescale 1ns/1ps
module jmb_mem_ctrl
  import jmb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  frame_t            req_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] din_i,
  output logic              strobe_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [NBLK-1:0]   cs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_start_o,
  output logic              acc_done_o
);
  logic [BLK_W-1:0] blk_q;
  logic             is_xfer_w;

  assign is_xfer_w   = (req_i.op == OP_READ) || (req_i.op == OP_WRITE);
  assign acc_start_o = start_i && !strobe_o && is_xfer_w;
  assign acc_done_o  = strobe_o && ack_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      strobe_o <= 1'b0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
      cs_o     <= '0;
      addr_o   <= '0;
      dout_o   <= '0;
      blk_q    <= '0;
      result_o <= '0;
    end else if (strobe_o) begin
      if (ack_i) begin
        strobe_o <= 1'b0;
        rd_o     <= 1'b0;
        wr_o     <= 1'b0;
        cs_o     <= '0;
        if (rd_o) result_o <= din_i & data_mask(blk_q);
      end
    end else if (start_i) begin
      case (req_i.op)
        OP_READ, OP_WRITE: begin
          strobe_o <= 1'b1;
          rd_o     <= (req_i.op == OP_READ);
          wr_o     <= (req_i.op == OP_WRITE);
          cs_o     <= block_select(req_i.blk);
          addr_o   <= req_i.addr & addr_mask(req_i.blk);
          dout_o   <= (req_i.op == OP_WRITE) ? (req_i.data & data_mask(req_i.blk)) : '0;
          blk_q    <= req_i.blk;
        end
        OP_QUERY: result_o <= geometry_word(req_i.blk);
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/jtag_mem_bridge.sv
`timescale 1ns/1ps
module jtag_mem_bridge
  import jmb_pkg::*;
#(
  parameter logic TAP_RST_ACT = 1'b1,
  parameter logic SHIFT_ACT   = 1'b1,
  parameter logic SYS_RST_ACT = 1'b1,
  parameter int   SYNC_STAGES = 2
) (
  input  logic              tck_i,
  input  logic              tap_rst_i,
  input  logic              shift_en_i,
  input  logic              update_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              sys_clk_i,
  input  logic              sys_rst_i,
  output logic              mem_strobe_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic              mem_ack_i,
  output logic [NBLK-1:0]   mem_cs_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [DATA_W-1:0] mem_din_i,
  output logic [DATA_W-1:0] mem_dout_o
);
  logic              sys_rst_w;
  frame_t            frame_w;
  logic              upd_lvl_w;
  logic              upd_rise_w;
  logic [DATA_W-1:0] result_w;
  logic              acc_start_w;
  logic              acc_done_w;

  assign sys_rst_w = (sys_rst_i == SYS_RST_ACT);

  jmb_scan_reg #(.SHIFT_ACT(SHIFT_ACT), .TAP_RST_ACT(TAP_RST_ACT)) u_scan (
    .tck_i    (tck_i),
    .tap_rst_i(tap_rst_i),
    .shift_i  (shift_en_i),
    .update_i (update_i),
    .tdi_i    (tdi_i),
    .result_i (result_w),
    .tdo_o    (tdo_o),
    .frame_o  (frame_w),
    .upd_lvl_o(upd_lvl_w)
  );

  jmb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (sys_clk_i),
    .rst_i  (sys_rst_w),
    .level_i(upd_lvl_w),
    .rise_o (upd_rise_w)
  );

  jmb_mem_ctrl u_ctrl (
    .clk_i      (sys_clk_i),
    .rst_i      (sys_rst_w),
    .start_i    (upd_rise_w),
    .req_i      (frame_w),
    .ack_i      (mem_ack_i),
    .din_i      (mem_din_i),
    .strobe_o   (mem_strobe_o),
    .rd_o       (mem_rd_o),
    .wr_o       (mem_wr_o),
    .cs_o       (mem_cs_o),
    .addr_o     (mem_addr_o),
    .dout_o     (mem_dout_o),
    .result_o   (result_w),
    .acc_start_o(acc_start_w),
    .acc_done_o (acc_done_w)
  );
endmodule

// File: rtl/jmb_checker.sv
`timescale 1ns/1ps
module jmb_checker
  import jmb_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic              strobe_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic              ack_i,
  input logic              acc_start_i,
  input logic              acc_done_i,
  input logic [NBLK-1:0]   cs_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] dout_i
);
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rd_i && wr_i));

  // R5
  dir_present_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |-> (rd_i || wr_i));

  // R6
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    strobe_i |-> ($countones(cs_i) == 1));

  // R6
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !strobe_i |-> (cs_i == '0));

  // R4
  hold_until_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (strobe_i && !ack_i) |=> (strobe_i && $stable(cs_i) && $stable(addr_i)
                               && $stable(dout_i) && $stable(rd_i) && $stable(wr_i)));

  // R4
  release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_done_i |=> !strobe_i);

  // R3
  launch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_start_i |=> $rose(strobe_i));
endmodule

bind jtag_mem_bridge jmb_checker u_jmb_chk (
  .clk_i      (sys_clk_i),
  .rst_i      (sys_rst_w),
  .strobe_i   (mem_strobe_o),
  .rd_i       (mem_rd_o),
  .wr_i       (mem_wr_o),
  .ack_i      (mem_ack_i),
  .acc_start_i(acc_start_w),
  .acc_done_i (acc_done_w),
  .cs_i       (mem_cs_o),
  .addr_i     (mem_addr_o),
  .dout_i     (mem_dout_o)
);

// File: tb/jtag_mem_bridge_bench.sv
`timescale 1ns/1ps
module jtag_mem_bridge_bench;
  localparam int FW = 39;

  logic sys_clk = 1'b0;
  always #4 sys_clk = ~sys_clk;

  logic tck = 0, tap_rst = 1, shift_en = 0, update = 0, tdi = 0, sys_rst = 1, mem_ack = 0;
  logic [15:0] mem_din = '0;
  logic tdo, strobe, rd, wr;
  logic [3:0]  cs;
  logic [18:0] addr;
  logic [15:0] dout;

  jtag_mem_bridge u_jtag_mem_bridge (
    .tck_i(tck), .tap_rst_i(tap_rst), .shift_en_i(shift_en), .update_i(update), .tdi_i(tdi),
    .tdo_o(tdo), .sys_clk_i(sys_clk), .sys_rst_i(sys_rst), .mem_strobe_o(strobe),
    .mem_rd_o(rd), .mem_wr_o(wr), .mem_ack_i(mem_ack), .mem_cs_o(cs), .mem_addr_o(addr),
    .mem_din_i(mem_din), .mem_dout_o(dout)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // geometry from the requirements (R7)
  function automatic int b_aw(input int b);
    if (b <= 1) return 18; else if (b == 2) return 19; else return 8;
  endfunction
  function automatic int b_dw(input int b);
    return (b <= 1) ? 16 : 8;
  endfunction
  function automatic logic [18:0] b_amask(input int b);
    return 19'((64'd1 << b_aw(b)) - 1);
  endfunction
  function automatic logic [15:0] b_dmask(input int b);
    return 16'((64'd1 << b_dw(b)) - 1);
  endfunction
  function automatic logic [FW-1:0] mk(input int op, input int b, input int a, input int d);
    return {d[15:0], a[18:0], b[1:0], op[1:0]};
  endfunction

  // ---------------- reference model ----------------
  logic [FW-1:0] last_frame = '0, m_hold = '0;
  logic m_upd = 0, q1 = 0, q2 = 0, q3 = 0;
  logic m_strobe = 0, m_rd = 0, m_wr = 0;
  logic [3:0]  m_cs = '0;
  logic [18:0] m_addr = '0;
  logic [15:0] m_dout = '0, m_result = '0;
  int m_blk = 0, m_cnt = 0, ack_lat = 2;
  logic [15:0] mem [int];

  always @(posedge sys_clk) begin
    if (sys_rst) begin
      q1 <= 0; q2 <= 0; q3 <= 0; m_strobe <= 0; m_rd <= 0; m_wr <= 0; m_cs <= '0; m_result <= '0;
    end else begin
      q1 <= m_upd; q2 <= q1; q3 <= q2;
      if (m_strobe) begin
        if (mem_ack) begin
          m_strobe <= 0;
          if (m_rd) m_result <= mem_din & b_dmask(m_blk);
        end
      end else if (q2 && !q3) begin
        if (m_hold[1:0] == 2'b01 || m_hold[1:0] == 2'b10) begin
          m_strobe <= 1;
          m_rd     <= (m_hold[1:0] == 2'b01);
          m_wr     <= (m_hold[1:0] == 2'b10);
          m_blk    <= int'(m_hold[3:2]);
          m_cs     <= 4'd1 << m_hold[3:2];
          m_addr   <= m_hold[22:4] & b_amask(int'(m_hold[3:2]));
          m_dout   <= m_hold[38:23] & b_dmask(int'(m_hold[3:2]));
        end else if (m_hold[1:0] == 2'b11) begin
          m_result <= {8'(b_aw(int'(m_hold[3:2]))), 8'(b_dw(int'(m_hold[3:2])))};
        end
      end
    end
  end

  // memory responder
  always @(negedge sys_clk) begin
    if (m_strobe) begin
      if (m_cnt == ack_lat) begin
        mem_ack = 1;
        if (m_wr) mem[(m_blk << 20) | int'(m_addr)] = m_dout;
        else mem_din = (mem.exists((m_blk << 20) | int'(m_addr)) ? mem[(m_blk << 20) | int'(m_addr)] : 16'h0)
                       | ~b_dmask(m_blk);
      end else mem_ack = 0;
      m_cnt++;
    end else begin
      mem_ack = 0;
      m_cnt = 0;
    end
  end

  // per-clock comparison
  always @(negedge sys_clk) begin
    if (!done) begin
      chk("R4 strobe", 64'(strobe), 64'(m_strobe));
      if (m_strobe) begin
        chk("R5 rd", 64'(rd), 64'(m_rd));
        chk("R5 wr", 64'(wr), 64'(m_wr));
        chk("R6 cs", 64'(cs), 64'(m_cs));
        chk("R7 addr", 64'(addr), 64'(m_addr));
        if (m_wr) chk("R7 dout", 64'(dout), 64'(m_dout));
      end
    end
  end

  task automatic summary();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge sys_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      summary();
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tck_pulse();
    @(negedge sys_clk); tck = 1;
    @(negedge sys_clk); tck = 0;
  endtask

  task automatic shift_frame(input logic [FW-1:0] f, output logic [FW-1:0] got);
    shift_en = 1;
    for (int i = 0; i < FW; i++) begin
      tdi = f[i];
      got[i] = tdo;
      tck_pulse();
    end
    shift_en = 0;
    last_frame = f;
  endtask

  task automatic do_update();
    update = 1;
    @(negedge sys_clk); tck = 1; m_upd = 1; m_hold = last_frame;
    @(negedge sys_clk); tck = 0; update = 0;
    @(negedge sys_clk); tck = 1; m_upd = 0;
    @(negedge sys_clk); tck = 0;
  endtask

  task automatic settle();
    repeat (6) @(negedge sys_clk);
    while (m_strobe) @(negedge sys_clk);
    repeat (3) @(negedge sys_clk);
  endtask

  task automatic access(input int op, input int b, input int a, input int d);
    logic [FW-1:0] junk;
    shift_frame(mk(op, b, a, d), junk);
    do_update();
    settle();
  endtask

  task automatic expect_result(input string tag, input logic [15:0] exp);
    logic [FW-1:0] got;
    shift_frame(mk(0, 0, 0, 0), got);
    chk(tag, 64'(got), 64'({exp, 23'b0}));
  endtask

  initial begin
    logic [FW-1:0] got;
    logic [FW-1:0] pat;
    repeat (3) tck_pulse();
    @(negedge sys_clk);
    // R12 reset state
    chk("R12 strobe in reset", 64'(strobe), 64'(0));
    chk("R12 cs in reset", 64'(cs), 64'(0));
    tap_rst = 0; sys_rst = 0;
    repeat (4) @(negedge sys_clk);
    // R2 / R12: result cleared at reset
    expect_result("R2 R12 capture after reset", 16'h0000);

    // R7 R3: write block 0 with an address bit above its width
    access(2, 0, 19'h7_1234, 16'hBEEF);
    // R7: write to block 2, data narrowed to 8 bits
    access(2, 2, 19'h7_FFFF, 16'hABCD);
    // R8: read back block 2
    access(1, 2, 19'h7_FFFF, 16'h0);
    expect_result("R8 read block2", 16'h00CD);
    // R8: read back block 0 (address masked to 18 bits aliases the written word)
    access(1, 0, 19'h3_1234, 16'h0);
    expect_result("R8 read block0", 16'hBEEF);
    // R7: block 3 keeps 8 address bits and 8 data bits
    access(2, 3, 19'h1_2345, 16'h1234);
    access(1, 3, 19'h0_0045, 16'h0);
    expect_result("R7 R8 read block3", 16'h0034);

    // R9: geometry query
    access(3, 2, 0, 0);
    expect_result("R9 query block2", 16'h1308);
    access(3, 0, 19'h7_FFFF, 16'hFFFF);
    expect_result("R9 query block0", 16'h1210);
    access(3, 3, 0, 0);
    expect_result("R9 query block3", 16'h0808);

    // R10: idle leaves the result unchanged
    access(0, 1, 19'h1_1111, 16'h5555);
    expect_result("R10 idle keeps result", 16'h0808);

    // R1: continuous shift of two frames; second half of TDO returns the first frame
    pat = mk(1, 2, 19'h5_A5A5, 16'hC3E1);
    shift_en = 1;
    for (int i = 0; i < 2*FW; i++) begin
      tdi = (i < FW) ? pat[i] : 1'b0;
      if (i >= FW) got[i-FW] = tdo;
      tck_pulse();
    end
    shift_en = 0;
    last_frame = '0;
    chk("R1 shift-through", 64'(got), 64'(pat));

    // R11: repeated update swept across a stalled transfer
    ack_lat = 4;
    for (int d = 0; d < 12; d++) begin
      access(2, 1, 100 + d, 16'h1000 + d);
      shift_frame(mk(((d % 2) == 0) ? 1 : 2, 1, 100 + d, 16'h2000 + d), got);
      do_update();
      repeat (d) @(negedge sys_clk);
      do_update();
      settle();
      expect_result("R11 R8 result after overlap", m_result);
    end
    ack_lat = 2;

    // R12: TAP reset clears the latched frame
    shift_frame(mk(2, 0, 5, 16'h7777), got);
    tap_rst = 1; tck_pulse(); tap_rst = 0;
    last_frame = '0;
    do_update();
    settle();
    chk("R12 no access after tap reset", 64'(strobe), 64'(0));
    access(1, 0, 5, 0);
    expect_result("R12 tap reset dropped write", 16'h0000);

    // R12: system reset in the middle of a transfer
    ack_lat = 200;
    access(1, 0, 19'h3_1234, 0);
    expect_result("R8 before sys reset", 16'hBEEF);
    shift_frame(mk(2, 1, 9, 16'h4242), got);
    do_update();
    repeat (8) @(negedge sys_clk);
    chk("R4 held while waiting", 64'(strobe), 64'(1));
    sys_rst = 1;
    repeat (3) @(negedge sys_clk);
    chk("R12 strobe after sys reset", 64'(strobe), 64'(0));
    sys_rst = 0;
    ack_lat = 2;
    repeat (4) @(negedge sys_clk);
    expect_result("R12 result cleared", 16'h0000);

    repeat (5) @(negedge sys_clk);
    summary();
  end
endmodule